// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the valid bits, register indices and instruction-class flags held in the pipeline registers. From these it produces the operand-forwarding selects for the execute stage, the hold enables for the program counter and the fetch/decode register, a bubble into the decode/execute register, and the flush strobes for the three front pipeline registers. All of these outputs are combinational functions of the current stage contents.

Instruction fetch and load/store traffic share one memory port. The instruction in the memory stage always wins that port, which guarantees that the older instruction keeps moving. Branches are assumed not taken and fetch carries on in sequence. A branch is resolved only when it reaches the memory stage. A taken branch, and any jump, therefore discards the three younger instructions and steers the program counter to the target. Both execute-stage source operands are forwarded the same way, because branches compare two registers directly and have no flags to read.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When `mem_valid` and `mem_is_mem` are both 1, `dport_grant` is 1 and `fetch_grant` is 0. Exactly one of the two grants is 1 in every cycle.
- R2: A memory-stage data access with no redirect in the same cycle drives `pc_hold`, `ifid_hold` and `idex_bubble` to 1.
- R3: With no memory-stage data access, `fetch_grant` is 1 and `dport_grant` is 0. With no hazard present, every hold, bubble and flush output is 0.
- R4: A valid memory-stage branch with `mem_br_taken`=1 drives `pc_redirect`, `ifid_flush`, `idex_flush` and `exmem_flush` to 1. A not-taken branch drives all four to 0.
- R5: A valid memory-stage jump (`mem_is_jump`=1) drives `pc_redirect` and all three flushes to 1, whatever `mem_br_taken` is.
- R6: A forwarding select equals 1 (memory-stage result) when its execute-stage source index equals `mem_rd` while `mem_valid` and `mem_wr_en` are 1.
- R7: Select encoding: 0 is the register file, 1 is the memory-stage result and 2 is the writeback-stage result. A writeback-stage match gives 2 only when there is no memory-stage match. When both stages match, the select is 1. When neither matches, it is 0.
- R8: Register index 0 never produces a nonzero forwarding select. A load whose destination is 0 never causes a load-use stall.
- R9: A load-use dependency drives `pc_hold`, `ifid_hold` and `idex_bubble` to 1 when no redirect is present. A load-use dependency is a valid load in execute, with `ex_wr_en`=1 and a nonzero `ex_rd`, whose `ex_rd` equals a decode-stage source that the decode instruction reads.
- R10: Whenever `pc_redirect` is 1, `pc_hold`, `ifid_hold` and `idex_bubble` are 0, even if a load-use or data-access stall is also present.
- R11: `fwd_a_sel` follows `ex_rs1` and `fwd_b_sel` follows `ex_rs2` independently, so the two operands can select different sources in the same cycle.
- R12: Stage entries with their valid bit at 0 cause no forwarding, stall, bubble, flush or data grant. With `ex_valid`=0, both selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the embedded checks) |
| rst | input | 1 | Synchronous active-high reset (used by the embedded checks) |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_rs1 | input | REG_AW | Decode first source index |
| id_rs2 | input | REG_AW | Decode second source index |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_rs1 | input | REG_AW | Execute first source index |
| ex_rs2 | input | REG_AW | Execute second source index |
| ex_rd | input | REG_AW | Execute destination index |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_rd | input | REG_AW | Memory-stage destination index |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_is_mem | input | 1 | Memory-stage instruction is a load or store |
| mem_is_branch | input | 1 | Memory-stage instruction is a conditional branch |
| mem_br_taken | input | 1 | Resolved branch outcome |
| mem_is_jump | input | 1 | Memory-stage instruction is an unconditional jump |
| wb_valid | input | 1 | Writeback stage holds an instruction |
| wb_rd | input | REG_AW | Writeback destination index |
| wb_wr_en | input | 1 | Writeback instruction writes a register |
| fwd_a_sel | output | 2 | First operand source select |
| fwd_b_sel | output | 2 | Second operand source select |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load an empty slot into decode/execute |
| ifid_flush | output | 1 | Invalidate fetch/decode |
| idex_flush | output | 1 | Invalidate decode/execute |
| exmem_flush | output | 1 | Invalidate execute/memory |
| pc_redirect | output | 1 | Load the resolved target into the program counter |
| dport_grant | output | 1 | Memory port serves the data access |
| fetch_grant | output | 1 | Memory port serves instruction fetch |

## Verification
Directed patterns cover each hazard on its own, including a load into register 0, a not-taken branch, a jump, and a register index matched in both later stages. These separate the forwarding priority, the register-0 exclusion and the different ways redirects are caused. Combined patterns set a taken branch or a jump together with a load-use dependency or a data access, which shows that a flush suppresses the stall. A long run with register indices drawn from a small set makes matches between stages frequent. A behavioural model checks every output on every cycle, so mixed cases such as one operand forwarded from each later stage are covered as well.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_EXMEM   = 2'd1,
        SRC_MEMWB   = 2'd2
    } fwd_src_e;

    typedef struct packed {
        logic data;
        logic fetch;
    } port_grant_t;

    typedef struct packed {
        logic hold_front;
        logic bubble;
        logic flush_front;
        logic redirect;
    } front_ctl_t;

    // A stage really writes a register only when valid, enabled and not x0
    function automatic logic writes_reg(input logic valid, input logic wr_en,
                                        input logic rd_nonzero);
        return valid & wr_en & rd_nonzero;
    endfunction

endpackage

// File: rtl/phz_fwd_sel.sv
module phz_fwd_sel
    import pipe_hazard_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              consumer_valid,
    input  logic [REG_AW-1:0] src_idx,
    input  logic              exmem_writes,
    input  logic [REG_AW-1:0] exmem_rd,
    input  logic              memwb_writes,
    input  logic [REG_AW-1:0] memwb_rd,
    output fwd_src_e          sel
);
    localparam logic [REG_AW-1:0] ZERO_IDX = '0;

    logic src_live;
    logic hit_exmem;
    logic hit_memwb;

    assign src_live  = consumer_valid && (src_idx != ZERO_IDX);
    assign hit_exmem = src_live && exmem_writes && (exmem_rd == src_idx);
    assign hit_memwb = src_live && memwb_writes && (memwb_rd == src_idx);

    always_comb begin
        if (hit_exmem)      sel = SRC_EXMEM;
        else if (hit_memwb) sel = SRC_MEMWB;
        else                sel = SRC_REGFILE;
    end

    // R8
    x0_never_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (src_idx == ZERO_IDX) |-> (sel == SRC_REGFILE));

    // R7
    wb_only_without_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_MEMWB) |-> !(exmem_writes && exmem_rd == src_idx));

    // R12
    idle_consumer_chk: assert property (@(posedge clk) disable iff (rst)
        !consumer_valid |-> (sel == SRC_REGFILE));

endmodule

// File: rtl/phz_load_use.sv
module phz_load_use #(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_rs1_used,
    input  logic              id_rs2_used,
    input  logic              ex_valid,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wr_en,
    input  logic              ex_is_load,
    output logic              hazard
);
    localparam int NSRC = 2;
    localparam logic [REG_AW-1:0] ZERO_IDX = '0;

    logic [REG_AW-1:0] src_idx  [NSRC];
    logic [NSRC-1:0]   src_used;
    logic [NSRC-1:0]   src_hit;
    logic              pending_load;

    assign src_idx[0]  = id_rs1;
    assign src_idx[1]  = id_rs2;
    assign src_used    = {id_rs2_used, id_rs1_used};
    assign pending_load = ex_valid && ex_is_load && ex_wr_en && (ex_rd != ZERO_IDX);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign src_hit[s] = src_used[s] && (src_idx[s] == ex_rd);
    end

    assign hazard = pending_load && id_valid && (|src_hit);

    // R8
    no_x0_load_use_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_rd == ZERO_IDX) |-> !hazard);

    // R12
    idle_decode_chk: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> !hazard);

endmodule

// File: rtl/phz_port_arb.sv
module phz_port_arb
    import pipe_hazard_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mem_valid,
    input  logic        mem_is_mem,
    output port_grant_t grant
);
    logic data_req;

    assign data_req    = mem_valid && mem_is_mem;
    assign grant.data  = data_req;
    assign grant.fetch = !data_req;

    // R1
    one_owner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({grant.data, grant.fetch}));

endmodule

// File: rtl/phz_front_ctl.sv
module phz_front_ctl
    import pipe_hazard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mem_valid,
    input  logic       mem_is_branch,
    input  logic       mem_br_taken,
    input  logic       mem_is_jump,
    input  logic       load_use,
    input  logic       port_busy,
    output front_ctl_t ctl
);
    logic resolved_taken;
    logic stall_req;

    // Predicted not-taken: any change of flow found in MEM is a mispredict
    assign resolved_taken  = mem_valid && (mem_is_jump || (mem_is_branch && mem_br_taken));
    assign stall_req       = load_use || port_busy;

    assign ctl.redirect    = resolved_taken;
    assign ctl.flush_front = resolved_taken;
    assign ctl.hold_front  = stall_req && !resolved_taken;
    assign ctl.bubble      = stall_req && !resolved_taken;

    // R10
    flush_beats_stall_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.redirect |-> (!ctl.hold_front && !ctl.bubble));

    // R4
    not_taken_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_is_branch && !mem_br_taken && !mem_is_jump) |-> !ctl.redirect);

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import pipe_hazard_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_rs1_used,
    input  logic              id_rs2_used,
    input  logic              ex_valid,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wr_en,
    input  logic              ex_is_load,
    input  logic              mem_valid,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wr_en,
    input  logic              mem_is_mem,
    input  logic              mem_is_branch,
    input  logic              mem_br_taken,
    input  logic              mem_is_jump,
    input  logic              wb_valid,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wr_en,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              idex_bubble,
    output logic              ifid_flush,
    output logic              idex_flush,
    output logic              exmem_flush,
    output logic              pc_redirect,
    output logic              dport_grant,
    output logic              fetch_grant
);
    localparam int NOPND = 2;
    localparam logic [REG_AW-1:0] ZERO_IDX = '0;

    logic              exmem_writes;
    logic              memwb_writes;
    logic [REG_AW-1:0] opnd_idx [NOPND];
    fwd_src_e          opnd_sel [NOPND];
    logic              load_use;
    port_grant_t       grant;
    front_ctl_t        ctl;

    assign exmem_writes = writes_reg(mem_valid, mem_wr_en, mem_rd != ZERO_IDX);
    assign memwb_writes = writes_reg(wb_valid, wb_wr_en, wb_rd != ZERO_IDX);
    assign opnd_idx[0]  = ex_rs1;
    assign opnd_idx[1]  = ex_rs2;

    // One identical selector per execute operand (ALU and branch compare alike)
    for (genvar k = 0; k < NOPND; k++) begin : g_opnd
        phz_fwd_sel #(.REG_AW(REG_AW)) u_sel (
            .clk            (clk),
            .rst            (rst),
            .consumer_valid (ex_valid),
            .src_idx        (opnd_idx[k]),
            .exmem_writes   (exmem_writes),
            .exmem_rd       (mem_rd),
            .memwb_writes   (memwb_writes),
            .memwb_rd       (wb_rd),
            .sel            (opnd_sel[k])
        );
    end

    phz_load_use #(.REG_AW(REG_AW)) u_lu (
        .clk         (clk),
        .rst         (rst),
        .id_valid    (id_valid),
        .id_rs1      (id_rs1),
        .id_rs2      (id_rs2),
        .id_rs1_used (id_rs1_used),
        .id_rs2_used (id_rs2_used),
        .ex_valid    (ex_valid),
        .ex_rd       (ex_rd),
        .ex_wr_en    (ex_wr_en),
        .ex_is_load  (ex_is_load),
        .hazard      (load_use)
    );

    phz_port_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .mem_valid  (mem_valid),
        .mem_is_mem (mem_is_mem),
        .grant      (grant)
    );

    phz_front_ctl u_front (
        .clk           (clk),
        .rst           (rst),
        .mem_valid     (mem_valid),
        .mem_is_branch (mem_is_branch),
        .mem_br_taken  (mem_br_taken),
        .mem_is_jump   (mem_is_jump),
        .load_use      (load_use),
        .port_busy     (grant.data),
        .ctl           (ctl)
    );

    assign fwd_a_sel   = opnd_sel[0];
    assign fwd_b_sel   = opnd_sel[1];
    assign pc_hold     = ctl.hold_front;
    assign ifid_hold   = ctl.hold_front;
    assign idex_bubble = ctl.bubble;
    assign ifid_flush  = ctl.flush_front;
    assign idex_flush  = ctl.flush_front;
    assign exmem_flush = ctl.flush_front;
    assign pc_redirect = ctl.redirect;
    assign dport_grant = grant.data;
    assign fetch_grant = grant.fetch;

    // R9
    load_use_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && ex_is_load && ex_wr_en && ex_rd != ZERO_IDX && id_valid &&
         id_rs1_used && id_rs1 == ex_rd && !pc_redirect)
        |-> (pc_hold && ifid_hold && idex_bubble));

    // R2
    data_access_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (dport_grant && !pc_redirect) |-> (pc_hold && idex_bubble));

    // R5
    jump_flushes_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_is_jump) |-> (ifid_flush && idex_flush && exmem_flush));

    // R12
    idle_mem_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_valid |-> (!pc_redirect && !dport_grant));

endmodule

// File: tb/pipe_hazard_ctrl_tb.sv
module pipe_hazard_ctrl_tb_top;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          id_valid, id_rs1_used, id_rs2_used;
    logic [AW-1:0] id_rs1, id_rs2;
    logic          ex_valid, ex_wr_en, ex_is_load;
    logic [AW-1:0] ex_rs1, ex_rs2, ex_rd;
    logic          mem_valid, mem_wr_en, mem_is_mem, mem_is_branch, mem_br_taken, mem_is_jump;
    logic [AW-1:0] mem_rd;
    logic          wb_valid, wb_wr_en;
    logic [AW-1:0] wb_rd;
    logic [1:0]    fwd_a_sel, fwd_b_sel;
    logic          pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush, exmem_flush;
    logic          pc_redirect, dport_grant, fetch_grant;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pipe_hazard_ctrl #(.REG_AW(AW)) dut_i (.*);

    task automatic idle();
        id_valid = 0; id_rs1 = 0; id_rs2 = 0; id_rs1_used = 0; id_rs2_used = 0;
        ex_valid = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_wr_en = 0; ex_is_load = 0;
        mem_valid = 0; mem_rd = 0; mem_wr_en = 0; mem_is_mem = 0;
        mem_is_branch = 0; mem_br_taken = 0; mem_is_jump = 0;
        wb_valid = 0; wb_rd = 0; wb_wr_en = 0;
    endtask

    // Behavioural reference: youngest producer first, scanned as a list
    function automatic int ref_src(int idx);
        int rds[2];
        bit wr[2];
        if (!ex_valid || idx == 0) return 0;
        rds[0] = int'(mem_rd); wr[0] = mem_valid && mem_wr_en;
        rds[1] = int'(wb_rd);  wr[1] = wb_valid && wb_wr_en;
        foreach (rds[p]) if (wr[p] && rds[p] == idx && rds[p] != 0) return p + 1;
        return 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        bit taken, data, lu, stall;
        taken = mem_valid && (mem_is_jump || (mem_is_branch && mem_br_taken));
        data  = mem_valid && mem_is_mem;
        lu    = 0;
        if (ex_valid && ex_is_load && ex_wr_en && ex_rd != 0 && id_valid) begin
            if (id_rs1_used && id_rs1 == ex_rd) lu = 1;
            if (id_rs2_used && id_rs2 == ex_rd) lu = 1;
        end
        stall = (lu || data) && !taken;
        chk(tag, "fwd_a_sel",   int'(fwd_a_sel),   ref_src(int'(ex_rs1)));
        chk(tag, "fwd_b_sel",   int'(fwd_b_sel),   ref_src(int'(ex_rs2)));
        chk(tag, "pc_hold",     int'(pc_hold),     int'(stall));
        chk(tag, "ifid_hold",   int'(ifid_hold),   int'(stall));
        chk(tag, "idex_bubble", int'(idex_bubble), int'(stall));
        chk(tag, "ifid_flush",  int'(ifid_flush),  int'(taken));
        chk(tag, "idex_flush",  int'(idex_flush),  int'(taken));
        chk(tag, "exmem_flush", int'(exmem_flush), int'(taken));
        chk(tag, "pc_redirect", int'(pc_redirect), int'(taken));
        chk(tag, "dport_grant", int'(dport_grant), int'(data));
        chk(tag, "fetch_grant", int'(fetch_grant), int'(!data));
    endtask

    // Drive at the falling edge, sample 1 ns later (outputs are combinational)
    task automatic step(string tag);
        @(negedge clk);
        #1;
        compare(tag);
    endtask

    initial begin
        idle();
        // Reset state with every stage empty
        step("R12 reset");
        repeat (2) @(posedge clk);
        rst = 0;

        idle(); step("R3 idle");

        idle(); mem_valid = 1; mem_is_mem = 1; step("R1 data access");
        chk("R2", "pc_hold on data access", int'(pc_hold), 1);

        idle(); mem_valid = 1; mem_is_branch = 1; mem_br_taken = 1; step("R4 taken");
        idle(); mem_valid = 1; mem_is_branch = 1; mem_br_taken = 0; step("R4 not taken");
        idle(); mem_valid = 1; mem_is_jump = 1; step("R5 jump");

        idle(); ex_valid = 1; ex_rs1 = 7; mem_valid = 1; mem_wr_en = 1; mem_rd = 7;
        step("R6 exmem fwd");
        chk("R6", "fwd_a_sel exmem", int'(fwd_a_sel), 1);

        idle(); ex_valid = 1; ex_rs1 = 9; mem_valid = 1; mem_wr_en = 1; mem_rd = 9;
        wb_valid = 1; wb_wr_en = 1; wb_rd = 9; step("R7 both match");
        chk("R7", "priority", int'(fwd_a_sel), 1);
        mem_rd = 3; step("R7 wb only");
        chk("R7", "wb select", int'(fwd_a_sel), 2);

        idle(); ex_valid = 1; ex_rs1 = 0; ex_rs2 = 0; mem_valid = 1; mem_wr_en = 1;
        wb_valid = 1; wb_wr_en = 1; step("R8 x0 operands");
        idle(); ex_valid = 1; ex_is_load = 1; ex_wr_en = 1; ex_rd = 0;
        id_valid = 1; id_rs1_used = 1; id_rs1 = 0; step("R8 load to x0");
        chk("R8", "no stall", int'(pc_hold), 0);

        idle(); ex_valid = 1; ex_is_load = 1; ex_wr_en = 1; ex_rd = 5;
        id_valid = 1; id_rs2_used = 1; id_rs2 = 5; id_rs1 = 5; step("R9 load-use rs2");
        chk("R9", "bubble", int'(idex_bubble), 1);
        id_rs2_used = 0; step("R9 unused source");

        mem_valid = 1; mem_is_branch = 1; mem_br_taken = 1; id_rs2_used = 1;
        step("R10 flush vs load-use");
        chk("R10", "pc_hold under flush", int'(pc_hold), 0);
        idle(); mem_valid = 1; mem_is_mem = 1; mem_is_jump = 1; step("R10 flush vs port");

        idle(); ex_valid = 1; ex_rs1 = 4; ex_rs2 = 6; mem_valid = 1; mem_wr_en = 1; mem_rd = 4;
        wb_valid = 1; wb_wr_en = 1; wb_rd = 6; step("R11 split operands");
        chk("R11", "fwd_b_sel", int'(fwd_b_sel), 2);

        idle(); ex_valid = 1; ex_rs1 = 2; mem_rd = 2; mem_wr_en = 1; mem_is_jump = 1;
        mem_is_mem = 1; step("R12 invalid mem");
        idle(); ex_is_load = 1; ex_wr_en = 1; ex_rd = 3; id_valid = 1;
        id_rs1_used = 1; id_rs1 = 3; ex_rs1 = 3; wb_valid = 1; wb_wr_en = 1; wb_rd = 3;
        step("R12 invalid ex");

        for (int n = 0; n < 3000; n++) begin
            id_valid = 1'($urandom); id_rs1 = AW'($urandom % 4); id_rs2 = AW'($urandom % 4);
            id_rs1_used = 1'($urandom); id_rs2_used = 1'($urandom);
            ex_valid = 1'($urandom); ex_rs1 = AW'($urandom % 4); ex_rs2 = AW'($urandom % 4);
            ex_rd = AW'($urandom % 4); ex_wr_en = 1'($urandom); ex_is_load = 1'($urandom);
            mem_valid = 1'($urandom); mem_rd = AW'($urandom % 4); mem_wr_en = 1'($urandom);
            mem_is_mem = ($urandom % 4) == 0; mem_is_branch = ($urandom % 4) == 0;
            mem_br_taken = 1'($urandom); mem_is_jump = ($urandom % 8) == 0;
            wb_valid = 1'($urandom); wb_rd = AW'($urandom % 4); wb_wr_en = 1'($urandom);
            step("R7 random mix");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule